// File: doc/BRIEF.md
# Streaming CRC-32C digest engine

The engine computes a 32-bit CRC-32C integrity digest over a segment of bytes, as used for header and data digests on a storage-over-IP link. Bytes arrive one per clock on a valid/ready stream. Each byte carries a start-of-segment and an end-of-segment flag. When a segment closes, the engine can extend it with zero bytes up to the next 4-byte boundary. These padding bytes enter the digest. The engine then presents the final digest for one cycle with a done strobe.

The register is kept in reflected form. Each byte enters least-significant bit first, and the register is updated with the reflected generator constant 0x82F63B78. That constant is the reflection of 0x1EDC6F41, which is the polynomial 0x11EDC6F41 with its x^32 term left implicit. The register starts each segment at all ones, and the output is its full complement. In check mode the computed digest is compared with a received digest, and a mismatch flag is raised together with done. The finished digest is also streamed out as four bytes, least-significant byte first by default. A parameter sets this order.

Top module: `crc32c_digest`

## Requirements
- R1: With padding disabled, the digest of the nine ASCII bytes "123456789" is 0xE3069283. In general, any segment's digest is the complement of a reflected CRC over polynomial 0x11EDC6F41 that starts from 0xFFFFFFFF and takes each byte LSB first.
- R2: An accepted byte with sof=1 reloads the initial value and starts a new segment, even when a segment is already open. The bytes of the abandoned segment have no effect on the next digest.
- R3: out_done is high for exactly one cycle. That cycle follows the clock edge that consumed the segment's last byte, or its last padding byte when padding is added. out_digest changes only at that edge and holds its value otherwise (0 after reset).
- R4: With pad_en=1 at the end-of-segment byte, a segment of n bytes where n mod 4 is not 0 is followed by 4 - (n mod 4) bytes of value 0x00. The digest equals that of the segment with those zero bytes appended explicitly.
- R5: in_ready is low for exactly the padding cycles, which start in the cycle after the end-of-segment byte is accepted. No input byte is taken while in_ready is low.
- R6: With pad_en=0 at the end-of-segment byte, no padding is added, for any length, and in_ready stays high.
- R7: out_mismatch is updated together with out_done. It is 1 when check_en was 1 at the finishing edge and the digest differs from rx_digest at that edge, and 0 otherwise. It keeps its value until the next finishing edge, or until an accepted sof byte clears it.
- R8: The engine streams the digest as four bytes on ser_valid/ser_byte. The stream starts in the out_done cycle and runs for four consecutive cycles, bits 7:0 first and then in order up to bits 31:24. A new digest restarts the stream.
- R9: An accepted byte that has sof=0 and arrives outside an open segment (before any sof, or after an end-of-segment) is ignored. Such a byte produces no done, even when it carries eof.
- R10: After reset, in_ready=1, out_done=0, out_digest=0, out_mismatch=0 and ser_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine can take a byte (low while padding) |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a segment |
| in_eof | input | 1 | Byte is the last of a segment |
| pad_en | input | 1 | Pad to a 4-byte boundary at end of segment |
| check_en | input | 1 | Compare the finished digest with rx_digest |
| rx_digest | input | 32 | Received digest for check mode |
| out_done | output | 1 | One-cycle strobe: digest finished |
| out_digest | output | 32 | Last finished digest |
| out_mismatch | output | 1 | Check mode: digest differed from rx_digest |
| ser_valid | output | 1 | Serialized digest byte valid |
| ser_byte | output | 8 | Serialized digest byte |

## Verification
The hardest situation to reach is an input that is held valid across the padding window. In that case bytes are offered while in_ready is low, and the next segment's sof must wait and then land on the first free cycle. The bench sends segments back to back with in_valid kept high through every boundary, using lengths of every residue mod 4. A per-clock behavioural model checks that the offered bytes are not taken early. The bench also opens a new segment in the middle of an open one, and sends stray bytes and a stray eof with no segment open, to exercise abandonment and the ignore rule.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

    localparam int DIG_W = 32;
    localparam int BYTE_W = 8;
    localparam int DIG_BYTES = DIG_W / BYTE_W;

    localparam logic [DIG_W-1:0] POLY_REFL = 32'h82F6_3B78;
    localparam logic [DIG_W-1:0] SEED      = 32'hFFFF_FFFF;
    localparam logic [DIG_W-1:0] FINAL_XOR = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_OPEN = 2'd1,
        SEQ_PAD  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic              en;
        logic              reload;
        logic [BYTE_W-1:0] data;
    } step_cmd_t;

    function automatic logic [DIG_W-1:0] crc_step(
        input logic [DIG_W-1:0]  cur,
        input logic [BYTE_W-1:0] b
    );
        logic [DIG_W-1:0] r;
        r = cur ^ {{(DIG_W-BYTE_W){1'b0}}, b};
        for (int i = 0; i < BYTE_W; i++) begin
            r = (r >> 1) ^ (POLY_REFL & {DIG_W{r[0]}});
        end
        return r;
    endfunction

endpackage

// File: rtl/crc32c_lane.sv
module crc32c_lane
    import crc32c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  step_cmd_t        cmd,
    output logic [DIG_W-1:0] crc_next
);
    logic [DIG_W-1:0] crc_q;

    always_comb begin
        crc_next = crc_step(cmd.reload ? SEED : crc_q, cmd.data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= SEED;
        end else if (cmd.en) begin
            crc_q <= crc_next;
        end
    end
endmodule

// File: rtl/crc32c_seq.sv
module crc32c_seq
    import crc32c_pkg::*;
#(
    parameter int ALIGN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              pad_en,
    output logic              in_ready,
    output step_cmd_t         cmd,
    output logic              fin,
    output logic              sof_taken
);
    localparam int CNT_W = (ALIGN > 1) ? $clog2(ALIGN) : 1;

    seq_state_t       state_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] pad_left_q;
    logic [CNT_W-1:0] cnt_new;
    logic             accept;
    logic             need_pad;

    assign in_ready = (state_q != SEQ_PAD);
    assign accept   = in_valid && in_ready;

    always_comb begin
        cmd       = '{en: 1'b0, reload: 1'b0, data: in_data};
        fin       = 1'b0;
        sof_taken = 1'b0;
        cnt_new   = (in_sof ? CNT_W'(0) : count_q) + CNT_W'(1);
        need_pad  = pad_en && (cnt_new != CNT_W'(0));
        if (state_q == SEQ_PAD) begin
            cmd.en   = 1'b1;
            cmd.data = '0;
            fin      = (pad_left_q == CNT_W'(1));
        end else if (accept) begin
            if (in_sof) begin
                sof_taken  = 1'b1;
                cmd.en     = 1'b1;
                cmd.reload = 1'b1;
            end else if (state_q == SEQ_OPEN) begin
                cmd.en = 1'b1;
            end
            if (cmd.en && in_eof && !need_pad) begin
                fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            count_q    <= '0;
            pad_left_q <= '0;
        end else if (state_q == SEQ_PAD) begin
            pad_left_q <= pad_left_q - CNT_W'(1);
            if (pad_left_q == CNT_W'(1)) begin
                state_q <= SEQ_IDLE;
            end
        end else if (cmd.en) begin
            count_q <= cnt_new;
            if (!in_eof) begin
                state_q <= SEQ_OPEN;
            end else if (need_pad) begin
                state_q    <= SEQ_PAD;
                pad_left_q <= CNT_W'(0) - cnt_new;
            end else begin
                state_q <= SEQ_IDLE;
            end
        end
    end
endmodule

// File: rtl/crc32c_serializer.sv
module crc32c_serializer
    import crc32c_pkg::*;
#(
    parameter bit LSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DIG_W-1:0]  value,
    output logic              ser_valid,
    output logic [BYTE_W-1:0] ser_byte
);
    localparam int LEFT_W = $clog2(DIG_BYTES + 1);

    logic [DIG_W-1:0]  shreg_q;
    logic [LEFT_W-1:0] left_q;

    assign ser_valid = (left_q != '0);

    generate
        if (LSB_FIRST) begin : g_lsb
            assign ser_byte = shreg_q[BYTE_W-1:0];
        end else begin : g_msb
            assign ser_byte = shreg_q[DIG_W-1 -: BYTE_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (load) begin
            shreg_q <= value;
            left_q  <= LEFT_W'(DIG_BYTES);
        end else if (ser_valid) begin
            left_q <= left_q - LEFT_W'(1);
            if (LSB_FIRST) begin
                shreg_q <= shreg_q >> BYTE_W;
            end else begin
                shreg_q <= shreg_q << BYTE_W;
            end
        end
    end
endmodule

// File: rtl/crc32c_digest.sv
module crc32c_digest
    import crc32c_pkg::*;
#(
    parameter int ALIGN         = 4,
    parameter bit SER_LSB_FIRST = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        pad_en,
    input  logic        check_en,
    input  logic [31:0] rx_digest,
    output logic        out_done,
    output logic [31:0] out_digest,
    output logic        out_mismatch,
    output logic        ser_valid,
    output logic [7:0]  ser_byte
);
    step_cmd_t        cmd;
    logic             fin;
    logic             sof_taken;
    logic [DIG_W-1:0] crc_next;
    logic [DIG_W-1:0] final_val;

    crc32c_seq #(.ALIGN(ALIGN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .pad_en    (pad_en),
        .in_ready  (in_ready),
        .cmd       (cmd),
        .fin       (fin),
        .sof_taken (sof_taken)
    );

    crc32c_lane u_lane (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .crc_next (crc_next)
    );

    assign final_val = crc_next ^ FINAL_XOR;

    crc32c_serializer #(.LSB_FIRST(SER_LSB_FIRST)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (fin),
        .value     (final_val),
        .ser_valid (ser_valid),
        .ser_byte  (ser_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_done     <= 1'b0;
            out_digest   <= '0;
            out_mismatch <= 1'b0;
        end else begin
            out_done <= fin;
            if (fin) begin
                out_digest   <= final_val;
                out_mismatch <= check_en && (final_val != rx_digest);
            end else if (sof_taken) begin
                out_mismatch <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/crc32c_digest_chk.sv
module crc32c_digest_chk #(
    parameter int ALIGN     = 4,
    parameter bit LSB_FIRST = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_sof,
    input logic        check_en,
    input logic [31:0] rx_digest,
    input logic        out_done,
    input logic [31:0] out_digest,
    input logic        out_mismatch,
    input logic        ser_valid,
    input logic [7:0]  ser_byte
);
    localparam int RUN_W = $clog2(ALIGN + 2);

    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || in_ready) begin
            low_run <= '0;
        end else if (low_run != RUN_W'(ALIGN + 1)) begin
            low_run <= low_run + RUN_W'(1);
        end
    end

    AST_PAD_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        int'(low_run) < ALIGN); // R5

    AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> $stable(out_digest)); // R3

    AST_MISMATCH_VALUE: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (out_mismatch == ($past(check_en) && (out_digest != $past(rx_digest))))); // R7

    AST_MISMATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!out_done && !$past(in_valid && in_ready && in_sof)) |-> $stable(out_mismatch)); // R7

    AST_SER_ALIGN: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (ser_valid && ser_byte == (LSB_FIRST ? out_digest[7:0] : out_digest[31:24]))); // R8
endmodule

bind crc32c_digest crc32c_digest_chk #(.ALIGN(ALIGN), .LSB_FIRST(SER_LSB_FIRST)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_sof       (in_sof),
    .check_en     (check_en),
    .rx_digest    (rx_digest),
    .out_done     (out_done),
    .out_digest   (out_digest),
    .out_mismatch (out_mismatch),
    .ser_valid    (ser_valid),
    .ser_byte     (ser_byte)
);

// File: tb/test_crc32c_digest.sv
`timescale 1ns/1ps
module test_crc32c_digest;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        pad_en = 1'b0;
    logic        check_en = 1'b0;
    logic [31:0] rx_digest = 32'h0;
    logic        out_done;
    logic [31:0] out_digest;
    logic        out_mismatch;
    logic        ser_valid;
    logic [7:0]  ser_byte;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    crc32c_digest i_crc32c_digest (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .pad_en(pad_en),
        .check_en(check_en), .rx_digest(rx_digest), .out_done(out_done),
        .out_digest(out_digest), .out_mismatch(out_mismatch),
        .ser_valid(ser_valid), .ser_byte(ser_byte)
    );

    function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (q[k]) begin
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ q[k][i];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'h82F63B78;
            end
        end
        return ~c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model, updated at every rising edge
    logic [7:0]  m_seg[$];
    logic [7:0]  m_ser[$];
    bit          m_open = 0;
    int          m_pad = 0;
    logic        m_done = 0;
    logic [31:0] m_dig = 0;
    logic        m_mis = 0;

    task automatic m_finish();
        m_dig  = ref_crc(m_seg);
        m_done = 1;
        m_mis  = check_en && (m_dig != rx_digest);
        m_ser  = {m_dig[7:0], m_dig[15:8], m_dig[23:16], m_dig[31:24]};
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_seg = {}; m_ser = {}; m_open = 0; m_pad = 0;
            m_done = 0; m_dig = 0; m_mis = 0;
        end else begin
            m_done = 0;
            if (m_ser.size() > 0) void'(m_ser.pop_front());
            if (m_pad > 0) begin
                m_seg.push_back(8'h00);
                m_pad--;
                if (m_pad == 0) m_finish();
            end else if (in_valid) begin
                if (in_sof) begin
                    m_seg = {}; m_open = 1; m_mis = 0;
                end
                if (m_open) begin
                    m_seg.push_back(in_data);
                    if (in_eof) begin
                        m_open = 0;
                        if (pad_en && (m_seg.size() % 4 != 0))
                            m_pad = 4 - (m_seg.size() % 4);
                        else
                            m_finish();
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R5 in_ready", {31'b0, in_ready}, {31'b0, m_pad == 0});
            check("R3 out_done", {31'b0, out_done}, {31'b0, m_done});
            check("R1 out_digest", out_digest, m_dig);
            check("R7 out_mismatch", {31'b0, out_mismatch}, {31'b0, m_mis});
            check("R8 ser_valid", {31'b0, ser_valid}, {31'b0, m_ser.size() > 0});
            if (m_ser.size() > 0) check("R8 ser_byte", {24'b0, ser_byte}, {24'b0, m_ser[0]});
        end
    end

    // drive one byte, waiting while the engine is padding
    task automatic send(input logic [7:0] d, input logic s, input logic e);
        bit ok;
        in_valid = 1; in_data = d; in_sof = s; in_eof = e;
        forever begin
            ok = in_ready;
            @(negedge clk);
            if (ok) break;
        end
    endtask

    task automatic send_seg(input logic [7:0] q[$]);
        foreach (q[k]) send(q[k], k == 0, k == q.size() - 1);
    endtask

    task automatic idle(input int n);
        in_valid = 0; in_sof = 0; in_eof = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(output logic [31:0] d, output bit seen);
        in_valid = 0; in_sof = 0; in_eof = 0;
        seen = 0; d = 0;
        for (int i = 0; i < 8; i++) begin
            if (out_done) begin d = out_digest; seen = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic count_done(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (out_done) cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  q[$];
        logic [7:0]  qz[$];
        logic [31:0] d;
        bit          seen;
        int          cnt;

        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state
        check("R10 in_ready", {31'b0, in_ready}, 32'd1);
        check("R10 out_done", {31'b0, out_done}, 32'd0);
        check("R10 out_digest", out_digest, 32'd0);
        check("R10 out_mismatch", {31'b0, out_mismatch}, 32'd0);
        check("R10 ser_valid", {31'b0, ser_valid}, 32'd0);

        // R1 check string, padding off
        q = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        pad_en = 0;
        send_seg(q);
        wait_done(d, seen);
        check("R1 check string", d, 32'hE3069283);
        check("R6 no padding, done seen", {31'b0, seen}, 32'd1);
        idle(5);

        // R7 check mode match then mismatch, then clear on sof
        check_en = 1; rx_digest = 32'hE3069283;
        send_seg(q);
        wait_done(d, seen);
        check("R7 match flag", {31'b0, out_mismatch}, 32'd0);
        rx_digest = 32'h12345678;
        send_seg(q);
        wait_done(d, seen);
        check("R7 mismatch flag", {31'b0, out_mismatch}, 32'd1);
        idle(2);
        check("R7 mismatch held", {31'b0, out_mismatch}, 32'd1);
        check_en = 0;
        send(8'hAA, 1, 0);
        check("R7 mismatch cleared by sof", {31'b0, out_mismatch}, 32'd0);
        send(8'hBB, 0, 1);
        idle(5);

        // R4 padding for every residue, compared with explicit zeros
        pad_en = 1;
        for (int n = 1; n <= 8; n++) begin
            q = {}; qz = {};
            for (int k = 0; k < n; k++) q.push_back(8'(k * 37 + n));
            qz = q;
            while (qz.size() % 4 != 0) qz.push_back(8'h00);
            send_seg(q);
            wait_done(d, seen);
            check("R4 padded digest", d, ref_crc(qz));
            idle(2);
        end

        // R5 back to back with valid held high through padding
        for (int r = 0; r < 6; r++) begin
            q = {};
            for (int k = 0; k < (r % 4) + 1; k++) q.push_back(8'(8'hC0 + r * 5 + k));
            send_seg(q);
        end
        idle(10);

        // R6 padding disabled, odd lengths
        pad_en = 0;
        q = {8'h01, 8'h02, 8'h03};
        send_seg(q);
        wait_done(d, seen);
        check("R6 unpadded digest", d, ref_crc(q));
        idle(3);

        // R2 sof mid-segment abandons
        pad_en = 1;
        send(8'h11, 1, 0); send(8'h22, 0, 0);
        q = {8'h55, 8'h66, 8'h77, 8'h88};
        send_seg(q);
        wait_done(d, seen);
        check("R2 restart digest", d, ref_crc(q));
        idle(3);

        // R9 stray bytes outside a segment
        send(8'h99, 0, 0); send(8'h98, 0, 1);
        idle(0);
        count_done(8, cnt);
        check("R9 no done from stray bytes", cnt, 0);
        q = {8'h5A};
        send_seg(q);
        wait_done(d, seen);
        check("R9 next digest unaffected", d, ref_crc({8'h5A, 8'h00, 8'h00, 8'h00}));
        idle(6);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule